// File: doc/BRIEF.md
# Interrupt Context Save/Restore Sequencer

This block sits next to a small processor core and carries out the hardware side of taking and leaving an interrupt. A device raises a request along with a 3-bit source number. The sequencer does not act on it until the core reports that its current instruction has finished. At that boundary it sends the device a one-cycle acknowledge. It then saves the core's program counter and status word on a private hardware stack and steers the program counter to the handler address held for that source. While the handler runs, further requests are masked. When the core signals a return, the sequencer pops the two saved words back, status word first, and hands them to the core through load strobes.

Handler addresses come from an eight-entry table. Software fills this table through a simple write port. The control stack is eight words deep by default. A push when the stack is full is refused and raises a sticky overflow flag. A pop from an empty stack returns zero and raises a sticky underflow flag. A busy output tells the core to stall instruction fetch while the save and restore steps run.

Top module: `irq_ctx_seq`

## Requirements
- R1: After synchronous reset, irq_ack, pc_load, psw_load, busy, in_service, stk_overflow and stk_underflow are all 0.
- R2: A request is accepted only on a clock edge where irq_req and instr_done are both 1 while the block is idle. irq_ack is 1 in the cycle after that edge and never while instr_done has not been seen.
- R3: irq_ack is high for exactly one cycle per accepted request.
- R4: After acceptance, the block spends one cycle pushing the PC and one cycle pushing the status word. busy is 1 from the cycle after the accepting edge until the vector is loaded.
- R5: Three cycles after the cycle in which irq_ack is high, pc_load pulses for one cycle. In that cycle pc_value holds the table entry for the accepted source number, busy falls to 0 and in_service rises to 1.
- R6: rti_req sampled while in_service is 1 raises busy in the next cycle. One cycle later psw_load pulses with the saved status word. One cycle after that pc_load pulses with the saved PC, while busy and in_service drop to 0.
- R7: While in_service or busy is 1, irq_req is ignored. A request still held when the return finishes is acknowledged one cycle after the final pc_load.
- R8: Writing vec_wdata to index vec_waddr with vec_we=1 replaces that table entry. Later entries to that source vector to the new address, and different sources use their own entries.
- R9: A push into a full stack sets stk_overflow, which stays set until reset, and leaves the stored words and the depth unchanged.
- R10: rti_req in the idle state with an empty stack runs the restore sequence. Zero values are loaded and stk_underflow is set; it stays set until reset.
- R11: The PC and status word that are saved are the values of core_pc and core_psw on the accepting edge. Later changes to those inputs have no effect on what is restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Device interrupt request, held until acknowledged |
| irq_num | input | NUM_W (3) | Source number of the request |
| instr_done | input | 1 | Core's current instruction has completed |
| rti_req | input | 1 | Core requests return from the handler |
| core_pc | input | PC_W (16) | Current program counter of the core |
| core_psw | input | PSW_W (8) | Current status word of the core |
| vec_we | input | 1 | Handler table write enable |
| vec_waddr | input | NUM_W (3) | Handler table write index |
| vec_wdata | input | PC_W (16) | Handler start address to write |
| irq_ack | output | 1 | One-cycle acknowledge to the device |
| pc_load | output | 1 | Core loads pc_value into its PC |
| pc_value | output | PC_W (16) | Handler address or restored PC |
| psw_load | output | 1 | Core loads psw_value into its status word |
| psw_value | output | PSW_W (8) | Restored status word |
| busy | output | 1 | Save or restore in progress; stall fetch |
| in_service | output | 1 | Handler running, requests masked |
| stk_overflow | output | 1 | Sticky: push refused on full stack |
| stk_underflow | output | 1 | Sticky: pop from empty stack |

## Verification
Requests are raised with instr_done held low for several cycles, and also with instr_done already high. This separates a design that waits for the instruction boundary from one that acknowledges at once. Core PC and status inputs are changed right after acceptance, which shows whether the values were captured on the accepting edge or tracked later. A request held through a whole handler and return tests masking and the timing of the re-acknowledge. Several sources, including one whose table entry is rewritten, show whether the vector lookup is indexed correctly. A one-deep instance and a stray return on an empty stack drive the overflow and underflow paths; in the one-deep case the popped status reveals whether a refused push damaged the stored word.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_PUSH_PC,
    SEQ_PUSH_PSW,
    SEQ_VECTOR,
    SEQ_SERVICE,
    SEQ_POP_PSW,
    SEQ_POP_PC
  } seq_state_t;

  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int unsigned NUM_W  = 3,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [NUM_W-1:0]  waddr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [NUM_W-1:0]  raddr,
  output logic [ADDR_W-1:0] rdata
);
  localparam int unsigned ENTRIES = 1 << NUM_W;

  logic [ADDR_W-1:0] mem [ENTRIES];

  // single write port, registered read: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              overflow,
  output logic              underflow
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  count;
  logic              full;
  logic              empty;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign wr_idx = IDX_W'(count);
  assign rd_idx = IDX_W'(count - CNT_W'(1));
  assign rdata  = empty ? '0 : mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push && !full) begin
      mem[wr_idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (push) begin
        if (full) overflow <= 1'b1;
        else      count    <= count + CNT_W'(1);
      end else if (pop) begin
        if (empty) underflow <= 1'b1;
        else       count     <= count - CNT_W'(1);
      end
    end
  end

  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (count == $past(count))); // R9
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R9
  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow); // R10

endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import irq_ctx_pkg::*;
#(
  parameter int unsigned NUM_W     = 3,
  parameter int unsigned PC_W      = 16,
  parameter int unsigned PSW_W     = 8,
  parameter int unsigned STK_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_req,
  input  logic [NUM_W-1:0] irq_num,
  input  logic             instr_done,
  input  logic             rti_req,
  input  logic [PC_W-1:0]  core_pc,
  input  logic [PSW_W-1:0] core_psw,
  input  logic             vec_we,
  input  logic [NUM_W-1:0] vec_waddr,
  input  logic [PC_W-1:0]  vec_wdata,
  output logic             irq_ack,
  output logic             pc_load,
  output logic [PC_W-1:0]  pc_value,
  output logic             psw_load,
  output logic [PSW_W-1:0] psw_value,
  output logic             busy,
  output logic             in_service,
  output logic             stk_overflow,
  output logic             stk_underflow
);
  localparam int unsigned WORD_W = max_w(PC_W, PSW_W);

  seq_state_t        state, nxt;
  logic [NUM_W-1:0]  num_q;
  logic [PC_W-1:0]   pc_q;
  logic [PSW_W-1:0]  psw_q;
  logic              accept;
  logic              stk_push;
  logic              stk_pop;
  logic [WORD_W-1:0] stk_wdata;
  logic [WORD_W-1:0] stk_rdata;
  logic [PC_W-1:0]   vec_rdata;

  assign accept = (state == SEQ_IDLE) && irq_req && instr_done;

  always_comb begin
    nxt = state;
    unique case (state)
      SEQ_IDLE: begin
        if (accept)       nxt = SEQ_PUSH_PC;
        else if (rti_req) nxt = SEQ_POP_PSW;
      end
      SEQ_PUSH_PC:  nxt = SEQ_PUSH_PSW;
      SEQ_PUSH_PSW: nxt = SEQ_VECTOR;
      SEQ_VECTOR:   nxt = SEQ_SERVICE;
      SEQ_SERVICE:  if (rti_req) nxt = SEQ_POP_PSW;
      SEQ_POP_PSW:  nxt = SEQ_POP_PC;
      SEQ_POP_PC:   nxt = SEQ_IDLE;
      default:      nxt = SEQ_IDLE;
    endcase
  end

  assign stk_push  = (state == SEQ_PUSH_PC) || (state == SEQ_PUSH_PSW);
  assign stk_pop   = (state == SEQ_POP_PSW) || (state == SEQ_POP_PC);
  assign stk_wdata = (state == SEQ_PUSH_PC) ? WORD_W'(pc_q) : WORD_W'(psw_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      num_q      <= '0;
      pc_q       <= '0;
      psw_q      <= '0;
      irq_ack    <= 1'b0;
      pc_load    <= 1'b0;
      pc_value   <= '0;
      psw_load   <= 1'b0;
      psw_value  <= '0;
      busy       <= 1'b0;
      in_service <= 1'b0;
    end else begin
      state      <= nxt;
      irq_ack    <= accept;
      if (accept) begin
        num_q <= irq_num;
        pc_q  <= core_pc;
        psw_q <= core_psw;
      end
      pc_load    <= (state == SEQ_VECTOR) || (state == SEQ_POP_PC);
      if (state == SEQ_VECTOR) pc_value <= vec_rdata;
      else if (state == SEQ_POP_PC) pc_value <= stk_rdata[PC_W-1:0];
      psw_load   <= (state == SEQ_POP_PSW);
      if (state == SEQ_POP_PSW) psw_value <= stk_rdata[PSW_W-1:0];
      busy       <= (nxt != SEQ_IDLE) && (nxt != SEQ_SERVICE);
      in_service <= (nxt == SEQ_SERVICE);
    end
  end

  irq_vec_table #(
    .NUM_W  (NUM_W),
    .ADDR_W (PC_W)
  ) u_vec_table (
    .clk   (clk),
    .we    (vec_we),
    .waddr (vec_waddr),
    .wdata (vec_wdata),
    .raddr (num_q),
    .rdata (vec_rdata)
  );

  irq_ctx_stack #(
    .DEPTH  (STK_DEPTH),
    .WORD_W (WORD_W)
  ) u_ctx_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (stk_push),
    .pop       (stk_pop),
    .wdata     (stk_wdata),
    .rdata     (stk_rdata),
    .overflow  (stk_overflow),
    .underflow (stk_underflow)
  );

  AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> $past(irq_req && instr_done)); // R2
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack); // R3
  AST_PSW_THEN_PC: assert property (@(posedge clk) disable iff (rst)
    psw_load |=> pc_load); // R6
  AST_MASKED_IN_SERVICE: assert property (@(posedge clk) disable iff (rst)
    (in_service || busy) |=> !irq_ack); // R7

endmodule

// File: tb/irq_ctx_seq_bench.sv
module irq_ctx_seq_bench;
  localparam time CLK_P = 8ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_req = 1'b0;
  logic [2:0]  irq_num = '0;
  logic        instr_done = 1'b0;
  logic        rti_req = 1'b0;
  logic [15:0] core_pc = '0;
  logic [7:0]  core_psw = '0;
  logic        vec_we = 1'b0;
  logic [2:0]  vec_waddr = '0;
  logic [15:0] vec_wdata = '0;

  logic        irq_ack, pc_load, psw_load, busy, in_service, ovf, unf;
  logic [15:0] pc_value;
  logic [7:0]  psw_value;
  logic        s_ack, s_pc_load, s_psw_load, s_busy, s_in_service, s_ovf, s_unf;
  logic [15:0] s_pc_value;
  logic [7:0]  s_psw_value;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] exp_vec [8];

  always #(CLK_P/2) clk = ~clk;

  irq_ctx_seq u_irq_ctx_seq (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_num(irq_num),
    .instr_done(instr_done), .rti_req(rti_req), .core_pc(core_pc),
    .core_psw(core_psw), .vec_we(vec_we), .vec_waddr(vec_waddr),
    .vec_wdata(vec_wdata), .irq_ack(irq_ack), .pc_load(pc_load),
    .pc_value(pc_value), .psw_load(psw_load), .psw_value(psw_value),
    .busy(busy), .in_service(in_service), .stk_overflow(ovf),
    .stk_underflow(unf)
  );

  irq_ctx_seq #(.STK_DEPTH(1)) u_irq_ctx_seq_d1 (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_num(irq_num),
    .instr_done(instr_done), .rti_req(rti_req), .core_pc(core_pc),
    .core_psw(core_psw), .vec_we(vec_we), .vec_waddr(vec_waddr),
    .vec_wdata(vec_wdata), .irq_ack(s_ack), .pc_load(s_pc_load),
    .pc_value(s_pc_value), .psw_load(s_psw_load), .psw_value(s_psw_value),
    .busy(s_busy), .in_service(s_in_service), .stk_overflow(s_ovf),
    .stk_underflow(s_unf)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_vec(input logic [2:0] idx, input logic [15:0] addr);
    vec_we = 1'b1; vec_waddr = idx; vec_wdata = addr;
    step();
    vec_we = 1'b0;
    exp_vec[idx] = addr;
  endtask

  // entry: request raised, instr_done withheld for wait_n cycles
  task automatic enter(input logic [2:0] num, input logic [15:0] pc,
                       input logic [7:0] psw, input int wait_n);
    irq_num = num; core_pc = pc; core_psw = psw;
    irq_req = 1'b1; instr_done = 1'b0;
    for (int i = 0; i < wait_n; i++) begin
      step();
      check("R2 no ack before boundary", irq_ack, 0);
    end
    instr_done = 1'b1;
    step();
    check("R2 ack after boundary", irq_ack, 1);
    check("R4 busy on entry", busy, 1);
    irq_req = 1'b0; instr_done = 1'b0;
    core_pc = ~pc; core_psw = ~psw;   // R11: later values must not be saved
    step();
    check("R3 ack single cycle", irq_ack, 0);
    check("R4 busy while pushing", busy, 1);
    step();
    check("R4 busy while pushing", busy, 1);
    step();
    check("R5 vector pc_load", pc_load, 1);
    check("R5 vector value", pc_value, exp_vec[num]);
    check("R5 busy released", busy, 0);
    check("R5 in_service", in_service, 1);
  endtask

  task automatic leave(input logic [15:0] pc, input logic [7:0] psw, input bit chk_small);
    rti_req = 1'b1;
    step();
    check("R6 busy on return", busy, 1);
    check("R6 no early psw_load", psw_load, 0);
    rti_req = 1'b0;
    step();
    check("R6 psw_load", psw_load, 1);
    check("R11 restored psw", psw_value, psw);
    if (chk_small) begin
      check("R9 refused push kept pc word", s_psw_value, pc[7:0]);
    end
    step();
    check("R6 pc_load", pc_load, 1);
    check("R11 restored pc", pc_value, pc);
    check("R6 busy cleared", busy, 0);
    check("R6 in_service cleared", in_service, 0);
    if (chk_small) begin
      check("R10 small stack pop empty", s_pc_value, 0);
      check("R10 small underflow", s_unf, 1);
    end
  endtask

  task automatic t_reset();
    check("R1 ack", irq_ack, 0);
    check("R1 pc_load", pc_load, 0);
    check("R1 psw_load", psw_load, 0);
    check("R1 busy", busy, 0);
    check("R1 in_service", in_service, 0);
    check("R1 overflow", ovf, 0);
    check("R1 underflow", unf, 0);
  endtask

  task automatic t_first();
    enter(3'd3, 16'h1234, 8'hA5, 3);
    check("R9 small overflow", s_ovf, 1);
    check("R9 deep stack no overflow", ovf, 0);
    leave(16'h1234, 8'hA5, 1'b1);
    check("R10 deep stack no underflow", unf, 0);
  endtask

  task automatic t_mask();
    enter(3'd5, 16'h2222, 8'h3C, 0);
    irq_num = 3'd6; core_pc = 16'h0ABC; core_psw = 8'h5A;
    irq_req = 1'b1; instr_done = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R7 masked in service", irq_ack, 0);
    end
    rti_req = 1'b1;
    step();
    check("R7 masked on return", irq_ack, 0);
    rti_req = 1'b0;
    step();
    check("R7 masked on return", irq_ack, 0);
    check("R11 restored psw", psw_value, 8'h3C);
    step();
    check("R7 masked on final load", irq_ack, 0);
    check("R11 restored pc", pc_value, 16'h2222);
    step();
    check("R7 held request acknowledged", irq_ack, 1);
    irq_req = 1'b0; instr_done = 1'b0;
    step(); step(); step();
    check("R8 source 6 vector", pc_value, exp_vec[6]);
    check("R8 pc_load", pc_load, 1);
    leave(16'h0ABC, 8'h5A, 1'b0);
  endtask

  task automatic t_vectors();
    write_vec(3'd2, 16'hBEEF);
    enter(3'd2, 16'h0F0F, 8'h81, 1);
    leave(16'h0F0F, 8'h81, 1'b0);
    enter(3'd7, 16'h7001, 8'h07, 0);
    leave(16'h7001, 8'h07, 1'b0);
    enter(3'd0, 16'hFFFE, 8'hFF, 2);
    leave(16'hFFFE, 8'hFF, 1'b0);
    check("R10 no underflow yet", unf, 0);
  endtask

  task automatic t_stray();
    rti_req = 1'b1;
    step();
    check("R10 stray return busy", busy, 1);
    rti_req = 1'b0;
    step();
    check("R10 psw_load", psw_load, 1);
    check("R10 psw zero", psw_value, 0);
    check("R10 underflow set", unf, 1);
    step();
    check("R10 pc_load", pc_load, 1);
    check("R10 pc zero", pc_value, 0);
    step(); step();
    check("R10 underflow sticky", unf, 1);
    check("R9 overflow untouched", ovf, 0);
  endtask

  initial begin
    repeat (4) step();
    rst = 1'b0;
    step();
    t_reset();
    for (int i = 0; i < 8; i++) begin
      write_vec(3'(i), 16'h4000 + 16'(i) * 16'h0101);
    end
    t_first();
    t_mask();
    t_vectors();
    t_stray();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule